// File: doc/BRIEF.md
# SCSI Host Interrupt and Status Unit

This unit holds the cause, status and sequence-step bytes of a small SCSI host controller, with a handful of neighbouring bytes that a completion clears: the FIFO-flags byte, three transfer-count bytes, a configuration byte and the captured completion status. It drives one level-sensitive interrupt line toward the host. Other parts of the controller report events on a plain event port: function complete, bus service, disconnect, bus reset and command complete. Each event loads its cause and status codes and requests an interrupt.

The host services an interrupt by reading the cause byte. That read has side effects. The old value comes back on the read data, and on the same clock edge the cause byte, the interrupt bit and the count-zero bit are cleared. A command-complete event that arrives while an interrupt is still pending is not lost. It is held in a one-deep latch and applied at the moment the host read clears the interrupt.

The event port and the host port are control ports. Neither has back-pressure. An event is taken in every cycle that `evt_valid` is high, and the host read data is a combinational view of the addressed byte.

Top module: `scsi_isu`

## Requirements
- R1: After reset every byte reads zero, except the configuration byte, which reads 8'h07. The `irq` output is low. Read addresses are: 0 cause, 1 status, 2 sequence step, 3 FIFO flags, 4/5/6 transfer count low/mid/high, 7 configuration, 8 completion status. Every other address reads zero.
- R2: A host read of address 0 (`host_rd` with `host_addr`=0) returns the old cause byte. On the same edge it sets cause to 0, clears status bits 7 (interrupt) and 4 (count zero), sets the sequence step to 8'h04 and lowers `irq`.
- R3: Event kind 0 (function complete) sets cause to 8'h08 and the sequence step to 0, then raises the interrupt.
- R4: Event kind 1 (bus service) sets cause to 8'h18, status to 8'h10 with `evt_phase` in bits 2:0, and the sequence step to 8'h04, then raises the interrupt.
- R5: Event kind 2 (disconnect) sets status to 0, cause to 8'h20 and the sequence step to 0, then raises the interrupt.
- R6: Event kind 3 (bus reset) sets cause to 8'h80. It raises the interrupt only when bit 6 of the configuration byte is clear.
- R7: Event kind 4 (command complete) with status bit 7 clear applies a completion. Status becomes 8'h13, cause becomes 8'h10, and the sequence step, FIFO flags and all three count bytes become 0. `evt_cstat` is stored at address 8 and the interrupt is raised.
- R8: A command-complete event that arrives while status bit 7 is set changes no readable byte. Its status is held as pending, and a later such event replaces the held status.
- R9: When a host read of address 0 finds a completion pending, the read clear is performed first. The held completion is then applied on the same edge, and the pending flag is cleared.
- R10: When an event and a host read of address 0 fall in the same cycle, the read clear takes effect first and the event then applies its codes.
- R11: Raising the interrupt sets status bit 7. `irq` equals status bit 7 in every cycle.
- R12: Event kinds 5 to 7 change nothing. Host writes are accepted only at addresses 3 to 7; writes to addresses 0, 1 and 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| host_addr | input | AW (4) | Register address for reads and writes |
| host_rd | input | 1 | Read strobe; enables the side effects of a cause-byte read |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for the addressed byte |
| evt_valid | input | 1 | An event is present this cycle |
| evt_kind | input | 3 | Event kind code (0 to 4 used) |
| evt_phase | input | 3 | Phase code loaded by a bus-service event |
| evt_cstat | input | 8 | Completion status carried by a command-complete event |
| irq | output | 1 | Level-sensitive interrupt line |

## Verification
A wrong ordering between the read clear, the pending completion and a same-cycle event shows up one edge after the cycle in question. The symptom is a cause or status byte that reads zero where a code was expected, or an `irq` that stays low. A pending latch that is stuck or leaks either hides a completion that should have appeared or lets the held completion overwrite the bytes too early; the next peek of address 0, 1 or 8 shows this. A broken raise or lower path shows on `irq` in the very next cycle, against status bit 7.

// File: rtl/scsi_isu_pkg.sv
package scsi_isu_pkg;

  // event kind codes
  typedef enum logic [2:0] {
    EVK_FUNC_DONE = 3'd0,
    EVK_BUS_SVC   = 3'd1,
    EVK_DISCONN   = 3'd2,
    EVK_BUS_RST   = 3'd3,
    EVK_CMD_DONE  = 3'd4
  } evt_kind_e;

  // register addresses
  localparam int ADR_CAUSE = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_STEP  = 2;
  localparam int ADR_FLAGS = 3;
  localparam int ADR_TCLO  = 4;
  localparam int ADR_TCMID = 5;
  localparam int ADR_TCHI  = 6;
  localparam int ADR_CFG   = 7;
  localparam int ADR_CPL   = 8;
  localparam int TC_BYTES  = 3;

  // cause codes
  localparam logic [7:0] CAUSE_FC   = 8'h08;
  localparam logic [7:0] CAUSE_BS   = 8'h10;
  localparam logic [7:0] CAUSE_DISC = 8'h20;
  localparam logic [7:0] CAUSE_RST  = 8'h80;

  // status bits and codes
  localparam int         ST_INT_BIT = 7;
  localparam int         ST_TCZ_BIT = 4;
  localparam logic [7:0] ST_TCZ     = 8'h10;
  localparam logic [7:0] ST_PHS_STS = 8'h03;

  // sequence step codes
  localparam logic [7:0] STEP_DONE = 8'h04;

endpackage

// File: rtl/scsi_isu_defer.sv
module scsi_isu_defer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_stat,
  input  logic       take,
  output logic       pend,
  output logic [7:0] pend_stat
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_stat <= 8'h00;
    end else if (load) begin
      pend      <= 1'b1;
      pend_stat <= load_stat;
    end else if (take) begin
      pend      <= 1'b0;
    end
  end

  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend); // R9

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !pend); // R9

endmodule

// File: rtl/scsi_isu_irq.sv
module scsi_isu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic lower,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (lower) irq <= 1'b0;
  end

  AST_RAISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    raise |-> !irq); // R11

  AST_LOWER_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lower |-> irq); // R11

endmodule

// File: rtl/scsi_isu_rdmux.sv
module scsi_isu_rdmux
  import scsi_isu_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             cause,
  input  logic [7:0]             stat,
  input  logic [7:0]             step,
  input  logic [7:0]             flags,
  input  logic [TC_BYTES-1:0][7:0] tc,
  input  logic [7:0]             cfg,
  input  logic [7:0]             cpl,
  output logic [7:0]             rdata
);

  always_comb begin
    rdata = 8'h00;
    if (addr == AW'(ADR_CAUSE)) rdata = cause;
    if (addr == AW'(ADR_STAT))  rdata = stat;
    if (addr == AW'(ADR_STEP))  rdata = step;
    if (addr == AW'(ADR_FLAGS)) rdata = flags;
    if (addr == AW'(ADR_CFG))   rdata = cfg;
    if (addr == AW'(ADR_CPL))   rdata = cpl;
    for (int i = 0; i < TC_BYTES; i++) begin
      if (addr == AW'(ADR_TCLO + i)) rdata = tc[i];
    end
  end

endmodule

// File: rtl/scsi_isu.sv
module scsi_isu
  import scsi_isu_pkg::*;
#(
  parameter int         AW           = 4,
  parameter logic [7:0] CFG_INIT     = 8'h07,
  parameter int         RST_MASK_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          evt_valid,
  input  logic [2:0]    evt_kind,
  input  logic [2:0]    evt_phase,
  input  logic [7:0]    evt_cstat,
  output logic          irq
);

  logic [7:0] cause_q, stat_q, step_q, flags_q, cfg_q, cpl_q;
  logic [TC_BYTES-1:0][7:0] tc_q;
  logic [7:0] cause_n, stat_n, step_n, flags_n, cfg_n, cpl_n;
  logic [TC_BYTES-1:0][7:0] tc_n;

  logic       rd_cause;
  logic       int_after_rd;
  logic       is_cmd_done;
  logic       evt_cpl;
  logic       pend_take;
  logic       pend_load;
  logic       cpl_go;
  logic [7:0] cpl_val;
  logic       pend_q;
  logic [7:0] pend_stat_q;
  logic       raise_req, lower_req;

  assign rd_cause     = host_rd && (host_addr == AW'(ADR_CAUSE));
  assign int_after_rd = rd_cause ? 1'b0 : stat_q[ST_INT_BIT];
  assign is_cmd_done  = evt_valid && (evt_kind == EVK_CMD_DONE);
  assign pend_take    = rd_cause && pend_q;
  assign evt_cpl      = is_cmd_done && !int_after_rd && !pend_take;
  assign pend_load    = is_cmd_done && !evt_cpl;
  assign cpl_go       = pend_take || evt_cpl;
  assign cpl_val      = pend_take ? pend_stat_q : evt_cstat;

  // ordered next-state chain: host write, read clear, completion, event
  always_comb begin
    cause_n = cause_q;
    stat_n  = stat_q;
    step_n  = step_q;
    flags_n = flags_q;
    tc_n    = tc_q;
    cfg_n   = cfg_q;
    cpl_n   = cpl_q;

    if (host_wr) begin
      if (host_addr == AW'(ADR_FLAGS)) flags_n = host_wdata;
      if (host_addr == AW'(ADR_CFG))   cfg_n   = host_wdata;
      for (int i = 0; i < TC_BYTES; i++) begin
        if (host_addr == AW'(ADR_TCLO + i)) tc_n[i] = host_wdata;
      end
    end

    if (rd_cause) begin
      cause_n             = 8'h00;
      stat_n[ST_INT_BIT]  = 1'b0;
      stat_n[ST_TCZ_BIT]  = 1'b0;
      step_n              = STEP_DONE;
    end

    if (cpl_go) begin
      stat_n             = ST_PHS_STS | ST_TCZ;
      cause_n            = CAUSE_BS;
      step_n             = 8'h00;
      flags_n            = 8'h00;
      tc_n               = '0;
      cpl_n              = cpl_val;
      stat_n[ST_INT_BIT] = 1'b1;
    end

    if (evt_valid) begin
      case (evt_kind)
        EVK_FUNC_DONE: begin
          cause_n            = CAUSE_FC;
          step_n             = 8'h00;
          stat_n[ST_INT_BIT] = 1'b1;
        end
        EVK_BUS_SVC: begin
          cause_n            = CAUSE_FC | CAUSE_BS;
          stat_n             = ST_TCZ | {5'b0, evt_phase};
          step_n             = STEP_DONE;
          stat_n[ST_INT_BIT] = 1'b1;
        end
        EVK_DISCONN: begin
          stat_n             = 8'h00;
          cause_n            = CAUSE_DISC;
          step_n             = 8'h00;
          stat_n[ST_INT_BIT] = 1'b1;
        end
        EVK_BUS_RST: begin
          cause_n = CAUSE_RST;
          if (!cfg_q[RST_MASK_BIT]) stat_n[ST_INT_BIT] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign raise_req = stat_n[ST_INT_BIT] && !stat_q[ST_INT_BIT];
  assign lower_req = !stat_n[ST_INT_BIT] && stat_q[ST_INT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= 8'h00;
      stat_q  <= 8'h00;
      step_q  <= 8'h00;
      flags_q <= 8'h00;
      tc_q    <= '0;
      cfg_q   <= CFG_INIT;
      cpl_q   <= 8'h00;
    end else begin
      cause_q <= cause_n;
      stat_q  <= stat_n;
      step_q  <= step_n;
      flags_q <= flags_n;
      tc_q    <= tc_n;
      cfg_q   <= cfg_n;
      cpl_q   <= cpl_n;
    end
  end

  scsi_isu_defer u_defer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pend_load),
    .load_stat (evt_cstat),
    .take      (pend_take),
    .pend      (pend_q),
    .pend_stat (pend_stat_q)
  );

  scsi_isu_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (raise_req),
    .lower (lower_req),
    .irq   (irq)
  );

  scsi_isu_rdmux #(.AW(AW)) u_rdmux (
    .addr  (host_addr),
    .cause (cause_q),
    .stat  (stat_q),
    .step  (step_q),
    .flags (flags_q),
    .tc    (tc_q),
    .cfg   (cfg_q),
    .cpl   (cpl_q),
    .rdata (host_rdata)
  );

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == stat_q[ST_INT_BIT]); // R11

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !evt_valid && !pend_q) |=> (!irq && cause_q == 8'h00 && step_q == STEP_DONE)); // R2

  AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd_done && stat_q[ST_INT_BIT] && !rd_cause) |=> (pend_q && $stable(cause_q) && $stable(stat_q) && $stable(cpl_q))); // R8

  AST_DEFER_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && pend_q && !evt_valid) |=> (cause_q == CAUSE_BS && irq && !pend_q)); // R9

  AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EVK_BUS_RST && cfg_q[RST_MASK_BIT] && !stat_q[ST_INT_BIT] && !rd_cause) |=> !irq); // R6

  AST_EVENT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && evt_valid && evt_kind == EVK_DISCONN) |=> (irq && cause_q == CAUSE_DISC)); // R10

endmodule

// File: tb/scsi_isu_bench.sv
`timescale 1ns/1ps
module scsi_isu_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] host_addr;
  logic       host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic       evt_valid;
  logic [2:0] evt_kind, evt_phase;
  logic [7:0] evt_cstat;
  logic       irq;

  int total = 0;
  int fails = 0;
  logic [7:0] last_rd;

  always #2.5 clk = ~clk;

  scsi_isu u_scsi_isu (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_phase(evt_phase),
    .evt_cstat(evt_cstat), .irq(irq)
  );

  typedef struct packed {
    logic       rd;
    logic       ev;
    logic [2:0] kind;
    logic [2:0] ph;
    logic [7:0] cst;
    logic       eirq;
    logic [7:0] ecause;
    logic [7:0] estat;
    logic [7:0] estep;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd0, 3'd0, 8'h00, 1'b1, 8'h08, 8'h80, 8'h00}, // R3
    '{1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h04}, // R2
    '{1'b0, 1'b1, 3'd1, 3'd1, 8'h00, 1'b1, 8'h18, 8'h91, 8'h04}, // R4
    '{1'b0, 1'b1, 3'd4, 3'd0, 8'h02, 1'b1, 8'h18, 8'h91, 8'h04}, // R8
    '{1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 8'h10, 8'h93, 8'h00}, // R9
    '{1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h03, 8'h04}, // R2
    '{1'b0, 1'b1, 3'd4, 3'd0, 8'h00, 1'b1, 8'h10, 8'h93, 8'h00}, // R7
    '{1'b1, 1'b1, 3'd2, 3'd0, 8'h00, 1'b1, 8'h20, 8'h80, 8'h00}, // R10 R5
    '{1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h04}, // R2
    '{1'b0, 1'b1, 3'd3, 3'd0, 8'h00, 1'b1, 8'h80, 8'h80, 8'h04}, // R6
    '{1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h04}, // R2
    '{1'b0, 1'b1, 3'd5, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h04}  // R12
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    evt_valid = 0; evt_kind = 0; evt_phase = 0; evt_cstat = 0;
  endtask

  // drive one cycle starting at a negedge; returns at the next negedge
  task automatic cyc(input logic rd, input logic wr, input logic [3:0] a, input logic [7:0] wd,
                     input logic ev, input logic [2:0] k, input logic [2:0] ph, input logic [7:0] cs);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    evt_valid = ev; evt_kind = k; evt_phase = ph; evt_cstat = cs;
    #1 last_rd = host_rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    host_addr = a;
    #0.5 v = host_rdata;
    host_addr = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(a, v);
    check(tag, v, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 10; a++)
      expect_reg($sformatf("R1 addr%0d", a), 4'(a), (a == 7) ? 8'h07 : 8'h00);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].rd, 1'b0, 4'd0, 8'h00, VEC[i].ev, VEC[i].kind, VEC[i].ph, VEC[i].cst);
      check($sformatf("vec%0d irq (R11)", i), {7'b0, irq}, {7'b0, VEC[i].eirq});
      expect_reg($sformatf("vec%0d cause", i), 4'd0, VEC[i].ecause);
      expect_reg($sformatf("vec%0d status", i), 4'd1, VEC[i].estat);
      expect_reg($sformatf("vec%0d step", i), 4'd2, VEC[i].estep);
    end

    // R2 old value returned by the clearing read
    cyc(0, 0, 0, 0, 1, 3'd0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    check("R2 old cause", last_rd, 8'h08);
    expect_reg("R2 cleared", 4'd0, 8'h00);

    // R7 completion clears flags and counts, stores status
    cyc(0, 1, 4'd3, 8'h5A, 0, 0, 0, 0);
    cyc(0, 1, 4'd4, 8'h12, 0, 0, 0, 0);
    cyc(0, 1, 4'd5, 8'h34, 0, 0, 0, 0);
    cyc(0, 1, 4'd6, 8'h56, 0, 0, 0, 0);
    expect_reg("R12 flags written", 4'd3, 8'h5A);
    expect_reg("R12 tc mid written", 4'd5, 8'h34);
    cyc(0, 0, 0, 0, 1, 3'd4, 0, 8'h22);
    expect_reg("R7 flags", 4'd3, 8'h00);
    expect_reg("R7 tclo", 4'd4, 8'h00);
    expect_reg("R7 tcmid", 4'd5, 8'h00);
    expect_reg("R7 tchi", 4'd6, 8'h00);
    expect_reg("R7 cstat", 4'd8, 8'h22);
    check("R7 irq", {7'b0, irq}, 8'h01);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);

    // R8 held completion replaced by a later one
    cyc(0, 0, 0, 0, 1, 3'd0, 0, 0);
    cyc(0, 0, 0, 0, 1, 3'd4, 0, 8'h11);
    cyc(0, 0, 0, 0, 1, 3'd4, 0, 8'h44);
    expect_reg("R8 cstat held", 4'd8, 8'h22);
    expect_reg("R8 cause held", 4'd0, 8'h08);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_reg("R9 cause", 4'd0, 8'h10);
    expect_reg("R9 cstat", 4'd8, 8'h44);
    check("R9 irq", {7'b0, irq}, 8'h01);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    check("R9 flag cleared irq", {7'b0, irq}, 8'h00);

    // R6 bus reset with reporting disabled
    cyc(0, 1, 4'd7, 8'h47, 0, 0, 0, 0);
    expect_reg("R6 cfg", 4'd7, 8'h47);
    cyc(0, 0, 0, 0, 1, 3'd3, 0, 0);
    check("R6 masked irq", {7'b0, irq}, 8'h00);
    expect_reg("R6 cause", 4'd0, 8'h80);

    // R12 writes to cause and status ignored
    cyc(0, 1, 4'd1, 8'hFF, 0, 0, 0, 0);
    cyc(0, 1, 4'd0, 8'hFF, 0, 0, 0, 0);
    cyc(0, 1, 4'd2, 8'hFF, 0, 0, 0, 0);
    expect_reg("R12 status", 4'd1, 8'h03);
    expect_reg("R12 cause", 4'd0, 8'h80);
    expect_reg("R12 step", 4'd2, 8'h04);
    cyc(0, 1, 4'd7, 8'h07, 0, 0, 0, 0);

    // R10 read and completion in the same cycle while irq high
    cyc(0, 0, 0, 0, 1, 3'd0, 0, 0);
    cyc(1, 0, 0, 0, 1, 3'd4, 0, 8'h66);
    check("R10 irq", {7'b0, irq}, 8'h01);
    expect_reg("R10 cause", 4'd0, 8'h10);
    expect_reg("R10 status", 4'd1, 8'h93);
    expect_reg("R10 cstat", 4'd8, 8'h66);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule